// File: doc/BRIEF.md
# Segment Display Two-Level Memory Updater

This block holds the pixel data of a segment display controller in two levels. Software fills a staging memory of sixteen 32-bit words over a small register bus. When the data is complete, software sets a pending-update flag. The block then copies the staging words into the display buffer that the waveform generator reads. Because of this, a frame is never drawn from a half-written picture.

The copy starts only at a frame boundary, marked by a one-cycle frame strobe, and only while the display is switched on. It then moves one word per clock. Each common owns two consecutive words. While the display is on, words belonging to commons beyond the programmed duty are skipped. If the display is switched off while a copy is running, every remaining word is copied whatever the duty. The staging memory is locked against bus writes while the update is pending. When the last word has been handled, the pending flag drops, a done flag rises, and an interrupt follows if it is enabled.

Bus map: addresses 0 to 15 are the staging words. Address 16 is the control register. On a write, bit 0 = 1 requests an update and bit 1 is the done-interrupt enable. On a read, bit 0 is pending, bit 1 is the enable and bit 2 is done. Address 17 is the done-clear register, where writing bit 0 = 1 clears done. Writes take effect at the clock edge on which bus_wr is high, and reads are combinational.

Top module: `seglcd_dbuf_updater`

## Requirements
- R1: After reset, all staging words, all display words, the pending flag, the done flag, the interrupt enable and upd_irq are 0.
- R2: A bus write to address 0..15 while upd_pending is 0 stores the data, and a read of the same address returns it.
- R3: A bus write to address 0..15 while upd_pending is 1 is ignored, and the staging word keeps its old value.
- R4: A control write with bit 0 = 1 sets upd_pending. A control write with bit 0 = 0 leaves upd_pending unchanged. Bit 1 of every control write is stored as the interrupt enable, read back at control bit 1.
- R5: With upd_pending = 1 and disp_en = 1 at a clock edge where frame_sof is 1, the copy starts. Exactly 16 edges later upd_pending becomes 0, upd_done becomes 1, and the display words hold the staging words.
- R6: While disp_en is 0, frame strobes start no copy: upd_pending stays 1, upd_done stays 0 and the display words are unchanged.
- R7: With disp_en held at 1 during a copy, word w is copied only if w/2 <= duty (duty = number of active commons minus 1), and all other display words keep their value.
- R8: Words handled at edges where disp_en is 0 during a running copy are copied regardless of duty.
- R9: A write of bit 0 = 1 to the clear register (address 17) clears upd_done, and a write of 0 there leaves it set.
- R10: upd_irq is 1 exactly when upd_done is 1 and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W (5) | Bus address for read and write |
| bus_wdata | input | WORD_W (32) | Bus write data |
| bus_rdata | output | WORD_W (32) | Bus read data, combinational from bus_addr |
| frame_sof | input | 1 | One-cycle frame start strobe |
| disp_en | input | 1 | Display enable state |
| duty | input | DUTY_W (3) | Active commons minus one |
| disp_words | output | NCOM*WPC*WORD_W (512) | Display buffer, word k at bits k*32 upward |
| upd_pending | output | 1 | Update request pending |
| upd_done | output | 1 | Update done flag |
| upd_irq | output | 1 | Done interrupt |

## Verification
Bus writes and flag changes appear one edge after the strobe, so the bench applies each stimulus at a falling edge and reads the result at the next falling edge. A copy admitted at edge E0 writes word k at edge E(k+1), and the flags change at E16. The bench therefore checks that upd_done is still 0 after fifteen further edges and set after the sixteenth. The test where the enable drops mid-copy removes disp_en after E4, so words 0..3 follow the duty and words 4..15 do not. Expected display contents come from a model array kept in the bench, updated from the requirement rules alone.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_COPY = 1'b1
   } seq_state_t;

   // control register bit positions (bus-visible)
   localparam int CTL_REQ_BIT  = 0;
   localparam int CTL_IE_BIT   = 1;
   localparam int CTL_DONE_BIT = 2;
   localparam int CLR_DONE_BIT = 0;
endpackage

// File: rtl/dbu_stage_ram.sv
module dbu_stage_ram #(
   parameter int NWORDS = 16,
   parameter int WORD_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic              lock_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [WORD_W-1:0] rd_data_o,
   input  logic [IDX_W-1:0]  cp_idx_i,
   output logic [WORD_W-1:0] cp_data_o
);
   logic [WORD_W-1:0] mem [NWORDS];

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[k] <= '0;
         else if (wr_en_i && !lock_i && wr_idx_i == IDX_W'(k))
            mem[k] <= wr_data_i;
      end

      // R3: a locked write leaves the word untouched
      a_r3_locked_write : assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i && lock_i && wr_idx_i == IDX_W'(k)) |=> $stable(mem[k]));
   end

   assign rd_data_o = mem[rd_idx_i];
   assign cp_data_o = mem[cp_idx_i];
endmodule

// File: rtl/dbu_copy_seq.sv
module dbu_copy_seq
   import dbu_pkg::*;
#(
   parameter int NWORDS = 16,
   parameter int WPC    = 2,
   parameter int IDX_W  = 4,
   parameter int DUTY_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              sof_i,
   input  logic              en_i,
   input  logic [DUTY_W-1:0] duty_i,
   output logic              cp_we_o,
   output logic [IDX_W-1:0]  cp_idx_o,
   output logic              done_o
);
   seq_state_t       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [31:0]      com_w;
   logic             last_w;
   logic             active_w;

   // common number of the current word: shift when words-per-common is 2^n
   if ((WPC & (WPC - 1)) == 0) begin : g_shift
      assign com_w = 32'(idx_q) >> $clog2(WPC);
   end else begin : g_div
      assign com_w = 32'(idx_q) / 32'(WPC);
   end

   assign last_w   = (idx_q == IDX_W'(NWORDS - 1));
   assign active_w = !en_i || (com_w <= 32'(duty_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (req_i && sof_i && en_i) begin
                  state_q <= SQ_COPY;
                  idx_q   <= '0;
               end
            end
            SQ_COPY: begin
               if (last_w)
                  state_q <= SQ_IDLE;
               idx_q <= idx_q + 1'b1;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign cp_we_o  = (state_q == SQ_COPY) && active_w;
   assign cp_idx_o = idx_q;
   assign done_o   = (state_q == SQ_COPY) && last_w;

   // R5: an admitted request begins the walk at word 0
   a_r5_start : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_IDLE && req_i && sof_i && en_i) |=>
         (state_q == SQ_COPY && idx_q == '0));

   // R6: nothing starts while the display is off
   a_r6_hold_off : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_IDLE && !en_i) |=> (state_q == SQ_IDLE));
endmodule

// File: rtl/dbu_disp_buf.sv
module dbu_disp_buf #(
   parameter int NWORDS = 16,
   parameter int WORD_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [WORD_W-1:0]        data_i,
   output logic [NWORDS*WORD_W-1:0] words_o
);
   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (we_i && idx_i == IDX_W'(k))
            word_q <= data_i;
      end
      assign words_o[k*WORD_W +: WORD_W] = word_q;
   end
endmodule

// File: rtl/dbu_flag_ctl.sv
module dbu_flag_ctl
   import dbu_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_i,
   input  logic              clr_wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              done_pulse_i,
   output logic              req_o,
   output logic              done_o,
   output logic              ie_o,
   output logic              irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_o  <= 1'b0;
         done_o <= 1'b0;
         ie_o   <= 1'b0;
      end else begin
         if (done_pulse_i)
            req_o <= 1'b0;
         else if (ctl_wr_i && wdata_i[CTL_REQ_BIT])
            req_o <= 1'b1;

         if (ctl_wr_i)
            ie_o <= wdata_i[CTL_IE_BIT];

         if (done_pulse_i)
            done_o <= 1'b1;
         else if (clr_wr_i && wdata_i[CLR_DONE_BIT])
            done_o <= 1'b0;
      end
   end

   assign irq_o = done_o & ie_o;

   // R5: the pending flag survives until the copy finishes
   a_r5_req_held : assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !done_pulse_i) |=> req_o);

   // R5: completion swaps the flags
   a_r5_done_set : assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse_i |=> (done_o && !req_o));

   // R9: done only falls through a clear write
   a_r9_done_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !(clr_wr_i && wdata_i[CLR_DONE_BIT])) |=> done_o);
endmodule

// File: rtl/seglcd_dbuf_updater.sv
module seglcd_dbuf_updater
   import dbu_pkg::*;
#(
   parameter int NCOM   = 8,
   parameter int WPC    = 2,
   parameter int WORD_W = 32,
   parameter int ADDR_W = $clog2(NCOM * WPC) + 1,
   parameter int DUTY_W = $clog2(NCOM)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_wr,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [WORD_W-1:0]             bus_wdata,
   output logic [WORD_W-1:0]             bus_rdata,
   input  logic                          frame_sof,
   input  logic                          disp_en,
   input  logic [DUTY_W-1:0]             duty,
   output logic [NCOM*WPC*WORD_W-1:0]    disp_words,
   output logic                          upd_pending,
   output logic                          upd_done,
   output logic                          upd_irq
);
   localparam int NWORDS = NCOM * WPC;
   localparam int IDX_W  = $clog2(NWORDS);
   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NWORDS);
   localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NWORDS + 1);

   if (NCOM < 2) begin : g_chk_ncom
      $error("NCOM must be at least 2");
   end
   if (WPC < 1) begin : g_chk_wpc
      $error("WPC must be at least 1");
   end
   if (WORD_W < 3) begin : g_chk_word
      $error("WORD_W too narrow for the control bits");
   end
   if ((NWORDS + 2) > (2 ** ADDR_W)) begin : g_chk_addr
      $error("ADDR_W cannot reach the control registers");
   end

   logic              ram_wr;
   logic              ctl_wr;
   logic              clr_wr;
   logic [WORD_W-1:0] ram_rd;
   logic [WORD_W-1:0] cp_data;
   logic              cp_we;
   logic [IDX_W-1:0]  cp_idx;
   logic              done_pulse;
   logic              ie;

   assign ram_wr = bus_wr && (bus_addr < CTL_ADDR);
   assign ctl_wr = bus_wr && (bus_addr == CTL_ADDR);
   assign clr_wr = bus_wr && (bus_addr == CLR_ADDR);

   dbu_stage_ram #(.NWORDS(NWORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (ram_wr),
      .wr_idx_i  (bus_addr[IDX_W-1:0]),
      .wr_data_i (bus_wdata),
      .lock_i    (upd_pending),
      .rd_idx_i  (bus_addr[IDX_W-1:0]),
      .rd_data_o (ram_rd),
      .cp_idx_i  (cp_idx),
      .cp_data_o (cp_data)
   );

   dbu_copy_seq #(.NWORDS(NWORDS), .WPC(WPC), .IDX_W(IDX_W), .DUTY_W(DUTY_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (upd_pending),
      .sof_i    (frame_sof),
      .en_i     (disp_en),
      .duty_i   (duty),
      .cp_we_o  (cp_we),
      .cp_idx_o (cp_idx),
      .done_o   (done_pulse)
   );

   dbu_disp_buf #(.NWORDS(NWORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_disp (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cp_we),
      .idx_i   (cp_idx),
      .data_i  (cp_data),
      .words_o (disp_words)
   );

   dbu_flag_ctl #(.WORD_W(WORD_W)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_wr_i     (ctl_wr),
      .clr_wr_i     (clr_wr),
      .wdata_i      (bus_wdata),
      .done_pulse_i (done_pulse),
      .req_o        (upd_pending),
      .done_o       (upd_done),
      .ie_o         (ie),
      .irq_o        (upd_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr < CTL_ADDR) begin
         bus_rdata = ram_rd;
      end else if (bus_addr == CTL_ADDR) begin
         bus_rdata[CTL_REQ_BIT]  = upd_pending;
         bus_rdata[CTL_IE_BIT]   = ie;
         bus_rdata[CTL_DONE_BIT] = upd_done;
      end
   end

   // R10: the interrupt never fires without a done flag behind it
   a_r10_irq_needs_done : assert property (@(posedge clk) disable iff (!rst_n)
      upd_irq |-> upd_done);
endmodule

// File: tb/sim_seglcd_dbuf_updater.sv
module sim_seglcd_dbuf_updater;
   localparam int CLK_PERIOD = 10;
   localparam int NCOM = 8;
   localparam int WPC  = 2;
   localparam int WW   = 32;
   localparam int NW   = NCOM * WPC;
   localparam int AW   = $clog2(NW) + 1;
   localparam int DW   = $clog2(NCOM);
   localparam int CTL  = NW;
   localparam int CLR  = NW + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [WW-1:0]     bus_wdata = '0;
   logic [WW-1:0]     bus_rdata;
   logic              frame_sof = 1'b0;
   logic              disp_en = 1'b0;
   logic [DW-1:0]     duty = '0;
   logic [NW*WW-1:0]  disp_words;
   logic              upd_pending, upd_done, upd_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 0;
   logic [WW-1:0] model [NW];

   seglcd_dbuf_updater u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_sof(frame_sof),
      .disp_en(disp_en), .duty(duty), .disp_words(disp_words),
      .upd_pending(upd_pending), .upd_done(upd_done), .upd_irq(upd_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [WW-1:0] pat(int w, int seed);
      return {8'(seed), 8'(w), ~8'(seed), 8'(w * 3 + seed)};
   endfunction

   task automatic check(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(int addr, logic [WW-1:0] data);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(int addr, output logic [WW-1:0] data);
      bus_addr = AW'(addr);
      #1;
      data = bus_rdata;
   endtask

   task automatic pulse_sof();
      @(negedge clk);
      frame_sof = 1'b1;
      @(negedge clk);
      frame_sof = 1'b0;
   endtask

   task automatic check_display(string tag);
      for (int w = 0; w < NW; w++)
         check(tag, disp_words[w*WW +: WW], model[w]);
   endtask

   task automatic t_reset();
      logic [WW-1:0] d;
      check("R1 pending", 32'(upd_pending), 0);
      check("R1 done", 32'(upd_done), 0);
      check("R1 irq", 32'(upd_irq), 0);
      bus_read(5, d);
      check("R1 stage word", d, 0);
      bus_read(CTL, d);
      check("R1 control", d, 0);
      for (int w = 0; w < NW; w++) model[w] = '0;
      check_display("R1 display");
   endtask

   task automatic t_write();
      logic [WW-1:0] d;
      for (int w = 0; w < NW; w++) bus_write(w, pat(w, 1));
      bus_read(0, d);  check("R2 word0", d, pat(0, 1));
      bus_read(7, d);  check("R2 word7", d, pat(7, 1));
      bus_read(15, d); check("R2 word15", d, pat(15, 1));
   endtask

   task automatic t_ctrl();
      logic [WW-1:0] d;
      bus_write(CTL, 32'h2);
      bus_read(CTL, d);
      check("R4 ie only", d, 32'h2);
      bus_write(CTL, 32'h3);
      check("R4 req set", 32'(upd_pending), 1);
      bus_write(CTL, 32'h2);
      check("R4 write 0 keeps req", 32'(upd_pending), 1);
   endtask

   task automatic t_protect();
      logic [WW-1:0] d;
      bus_write(3, pat(3, 9));
      bus_read(3, d);
      check("R3 locked word", d, pat(3, 1));
   endtask

   task automatic t_disabled();
      disp_en = 1'b0;
      pulse_sof();
      repeat (20) @(negedge clk);
      pulse_sof();
      repeat (20) @(negedge clk);
      check("R6 pending", 32'(upd_pending), 1);
      check("R6 done", 32'(upd_done), 0);
      check_display("R6 display");
   endtask

   task automatic t_full_copy();
      disp_en = 1'b1;
      duty = DW'(NCOM - 1);
      pulse_sof();
      repeat (15) @(negedge clk);
      check("R5 done early", 32'(upd_done), 0);
      check("R5 pending early", 32'(upd_pending), 1);
      @(negedge clk);
      check("R5 done", 32'(upd_done), 1);
      check("R5 pending clear", 32'(upd_pending), 0);
      for (int w = 0; w < NW; w++) model[w] = pat(w, 1);
      check_display("R5 display");
      check("R10 irq on", 32'(upd_irq), 1);
   endtask

   task automatic t_clear();
      bus_write(CLR, 32'h0);
      check("R9 clear 0", 32'(upd_done), 1);
      bus_write(CLR, 32'h1);
      check("R9 clear 1", 32'(upd_done), 0);
      check("R10 irq off", 32'(upd_irq), 0);
   endtask

   task automatic t_duty();
      for (int w = 0; w < NW; w++) bus_write(w, pat(w, 2));
      bus_write(CTL, 32'h1);
      duty = DW'(1);
      disp_en = 1'b1;
      pulse_sof();
      repeat (16) @(negedge clk);
      check("R7 done", 32'(upd_done), 1);
      check("R10 irq disabled", 32'(upd_irq), 0);
      for (int w = 0; w < NW; w++)
         if (w / WPC <= 1) model[w] = pat(w, 2);
      check_display("R7 display");
      bus_write(CLR, 32'h1);
   endtask

   task automatic t_drop();
      for (int w = 0; w < NW; w++) bus_write(w, pat(w, 3));
      bus_write(CTL, 32'h1);
      duty = '0;
      disp_en = 1'b1;
      pulse_sof();
      repeat (4) @(negedge clk);
      disp_en = 1'b0;
      repeat (12) @(negedge clk);
      check("R8 done", 32'(upd_done), 1);
      for (int w = 0; w < NW; w++)
         if (w < 2 || w >= 4) model[w] = pat(w, 3);
      check_display("R8 display");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_ctrl();
      t_protect();
      t_disabled();
      t_full_copy();
      t_clear();
      t_duty();
      t_drop();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!ended) begin
         ended = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule